// File: doc/BRIEF.md
# Trace Buffer Memory Attribute Register Access Guard

This block holds the control register that tells a trace buffer which memory type, cacheability and shareability to use for its stores, and it decides whether each software read or write of that register may proceed. For every request it looks at the requesting privilege level (0 to 3) and at control bits owned by levels 2 and 3: debug halt state, the secure-debug-disabled flag, fine-grained trap bits, a level-2 ownership field and a level-3 per-security-state ownership field. From these it produces one of four outcomes in the same cycle: allow, undefined instruction, trap to level 2, or trap to level 3. Both trap kinds carry the syndrome class 0x18.

An allowed write keeps only the ten defined bits of the register. It is dropped while the trace buffer is enabled, if the build parameter selects that behaviour. An allowed read returns the stored value with every upper bit zero. The block also gives the memory system the shareability it should use, with the override the memory type calls for, and a flag that marks reserved encodings.

Top module: `tbuf_attr_guard`

## Requirements
- R1: A valid request with `req_level` = 0 gives undefined (`res_onehot` = 4'b0100), whatever the control bits are.
- R2: A valid request with `req_level` = 3 is always allowed (`res_onehot` = 4'b1000).
- R3: At level 1 or 2, the first check gives undefined when the core is halted, level 3 is present, secure debug is disabled, the halt-priority option is set and the level-3 owner field mismatches. A mismatch is secure state with the owner field not equal to 2'b01, or non-secure state with it not equal to 2'b11.
- R4: At level 1, if level 2 is enabled and either level 3 is absent or `fgt_enable` = 1, a set trap bit for the request's direction gives trap to level 2 (4'b0010). A read looks only at `fgt_rd_trap` and a write looks only at `fgt_wr_trap`.
- R5: At level 1, after the fine-grained check, a request traps to level 2 when level 2 is enabled and bit 0 of `l2_owner` is 0.
- R6: At level 1 or 2, the last check is a level-3 owner mismatch with level 3 present. It gives trap to level 3 (4'b0001), or undefined when the core is halted and secure debug is disabled. A request that passes every check is allowed.
- R7: At level 2, neither the fine-grained bits nor `l2_owner` have any effect, so a level-2 request never traps to level 2.
- R8: `res_onehot` is {allow, undef, trap_l2, trap_l3} from bit 3 down to bit 0. Exactly one bit is set while `req_valid` = 1 and none while it is 0. `res_class` is 6'h18 on either trap and 0 otherwise.
- R9: The stored value resets to zero. An allowed write stores `req_wdata[9:0]` at the next clock edge: bits 9:8 are shareability and bits 7:0 the attribute byte. An allowed read returns it on `rd_data` in the same cycle, with bits 63:10 zero. `rd_data` is zero for every other request.
- R10: With `DROP_WHILE_ENABLED` = 1, an allowed write while `buf_enable` = 1 leaves the stored value unchanged. A write that is not allowed never changes it.
- R11: `eff_share` equals the stored shareability, except that it is 2'b10 (outer) when attribute bits 7:4 are 0000 (device memory) or the attribute byte is 0x44 (non-cacheable at both levels). The codes are 00 non-shareable, 10 outer and 11 inner.
- R12: `attr_reserved` is 1 when the memory type is device and attribute bits 3:0 are not one of 0000, 0100, 1000 or 1100. It is also 1 when no override applies and the stored shareability is the reserved code 01. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| halted | input | 1 | Core is in debug halt |
| el3_present | input | 1 | Level 3 is implemented |
| el2_enabled | input | 1 | Level 2 is enabled in the current state |
| secure | input | 1 | Requester is in secure state |
| sec_debug_off | input | 1 | Secure debug is disabled |
| halt_prio_opt | input | 1 | Implementation option that gives the halted undefined case priority |
| fgt_enable | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap bit for writes |
| l2_owner | input | 2 | Level-2 ownership field (bit 0 used) |
| l3_owner | input | 2 | Level-3 ownership field |
| buf_enable | input | 1 | Trace buffer is enabled |
| res_onehot | output | 4 | {allow, undef, trap_l2, trap_l3} |
| res_class | output | 6 | Syndrome class for traps |
| rd_data | output | 64 | Read data for allowed reads |
| eff_share | output | 2 | Effective shareability for the memory system |
| attr_reserved | output | 1 | Stored value uses a reserved encoding |

## Verification
The outcome, the syndrome class and the read data are combinational, so they are due in the same cycle as the request. The bench drives inputs just after a rising edge and compares these outputs with its model one time unit after the falling edge. A write that is allowed changes the stored value at the next rising edge, so the model's shadow copy is updated only after that edge. `eff_share`, `attr_reserved` and later reads are then compared one cycle after the write. A directed sequence reaches each step of the check chain, the dropped-write case and the share overrides, and a long random run is compared on every clock.

// File: rtl/tbuf_attr_pkg.sv
package tbuf_attr_pkg;

    localparam int SH_W    = 2;
    localparam int ATTR_W  = 8;
    localparam int CLASS_W = 6;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

    localparam logic [1:0] SH_NONE    = 2'b00;
    localparam logic [1:0] SH_RSVD    = 2'b01;
    localparam logic [1:0] SH_OUTER   = 2'b10;
    localparam logic [ATTR_W-1:0] ATTR_NC_BOTH = 8'h44;

    localparam logic [1:0] L3_OWN_SECURE    = 2'b01;
    localparam logic [1:0] L3_OWN_NONSECURE = 2'b11;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } priv_lvl_e;

    // Outcome index; the one-hot result is bit (3 - index)
    typedef enum logic [1:0] {
        OUT_ALLOW   = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    typedef struct packed {
        logic       halted;
        logic       el3_present;
        logic       el2_enabled;
        logic       secure;
        logic       sec_debug_off;
        logic       halt_prio_opt;
        logic       fgt_enable;
        logic       fgt_rd_trap;
        logic       fgt_wr_trap;
        logic [1:0] l2_owner;
        logic [1:0] l3_owner;
    } guard_ctx_t;

    typedef struct packed {
        logic [SH_W-1:0]   share;
        logic [ATTR_W-1:0] attr;
    } attr_reg_t;

    function automatic logic l3_owner_mismatch(input guard_ctx_t c);
        logic [1:0] want;
        want = c.secure ? L3_OWN_SECURE : L3_OWN_NONSECURE;
        return c.el3_present && (c.l3_owner != want);
    endfunction

    function automatic logic share_forced(input logic [ATTR_W-1:0] a);
        return (a[ATTR_W-1:ATTR_W/2] == '0) || (a == ATTR_NC_BOTH);
    endfunction

    function automatic logic [SH_W-1:0] effective_share(input attr_reg_t r);
        return share_forced(r.attr) ? SH_OUTER : r.share;
    endfunction

    function automatic logic encoding_reserved(input attr_reg_t r);
        logic dev_bad;
        dev_bad = (r.attr[ATTR_W-1:ATTR_W/2] == '0) && (r.attr[1:0] != 2'b00);
        return dev_bad || (!share_forced(r.attr) && r.share == SH_RSVD);
    endfunction

endpackage

// File: rtl/tbuf_access_decider.sv
module tbuf_access_decider
    import tbuf_attr_pkg::*;
#(
    parameter int                  CW    = CLASS_W,
    parameter logic [CLASS_W-1:0]  TCLS  = TRAP_CLASS
) (
    input  logic          valid,
    input  logic          write,
    input  priv_lvl_e     level,
    input  guard_ctx_t    ctx,
    output logic [3:0]    res_onehot,
    output logic [CW-1:0] res_class,
    output logic          allow
);
    outcome_e   outcome;
    logic       mism;
    logic       halt_undef;
    logic       fgt_applies;
    logic       fgt_hit;
    logic       l2_own_hit;

    always_comb begin
        mism        = l3_owner_mismatch(ctx);
        halt_undef  = ctx.halted && ctx.el3_present && ctx.sec_debug_off &&
                      ctx.halt_prio_opt && mism;
        fgt_applies = ctx.el2_enabled && (!ctx.el3_present || ctx.fgt_enable);
        fgt_hit     = fgt_applies && (write ? ctx.fgt_wr_trap : ctx.fgt_rd_trap);
        l2_own_hit  = ctx.el2_enabled && !ctx.l2_owner[0];

        outcome = OUT_ALLOW;
        unique case (level)
            LVL_0: outcome = OUT_UNDEF;
            LVL_3: outcome = OUT_ALLOW;
            LVL_1, LVL_2: begin
                if (halt_undef)
                    outcome = OUT_UNDEF;
                else if (level == LVL_1 && fgt_hit)
                    outcome = OUT_TRAP_L2;
                else if (level == LVL_1 && l2_own_hit)
                    outcome = OUT_TRAP_L2;
                else if (mism)
                    outcome = (ctx.halted && ctx.sec_debug_off) ? OUT_UNDEF : OUT_TRAP_L3;
                else
                    outcome = OUT_ALLOW;
            end
            default: outcome = OUT_UNDEF;
        endcase
    end

    always_comb begin
        res_onehot = '0;
        res_class  = '0;
        if (valid) begin
            res_onehot = 4'b1000 >> outcome;
            if (outcome == OUT_TRAP_L2 || outcome == OUT_TRAP_L3)
                res_class = TCLS;
        end
        allow = valid && (outcome == OUT_ALLOW);
    end

endmodule

// File: rtl/tbuf_attr_store.sv
module tbuf_attr_store
    import tbuf_attr_pkg::*;
#(
    parameter bit DROP_WHILE_ENABLED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req,
    input  logic            buf_enable,
    input  attr_reg_t       wr_val,
    output attr_reg_t       cur,
    output logic [SH_W-1:0] eff_share,
    output logic            reserved
);
    logic commit;

    generate
        if (DROP_WHILE_ENABLED) begin : g_drop
            assign commit = wr_req && !buf_enable;
        end else begin : g_keep
            assign commit = wr_req;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (commit)
            cur <= wr_val;
    end

    always_comb begin
        eff_share = effective_share(cur);
        reserved  = encoding_reserved(cur);
    end

endmodule

// File: rtl/tbuf_attr_guard.sv
module tbuf_attr_guard
    import tbuf_attr_pkg::*;
#(
    parameter int DATA_W             = 64,
    parameter bit DROP_WHILE_ENABLED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_level,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              halted,
    input  logic              el3_present,
    input  logic              el2_enabled,
    input  logic              secure,
    input  logic              sec_debug_off,
    input  logic              halt_prio_opt,
    input  logic              fgt_enable,
    input  logic              fgt_rd_trap,
    input  logic              fgt_wr_trap,
    input  logic [1:0]        l2_owner,
    input  logic [1:0]        l3_owner,
    input  logic              buf_enable,
    output logic [3:0]        res_onehot,
    output logic [CLASS_W-1:0] res_class,
    output logic [DATA_W-1:0] rd_data,
    output logic [SH_W-1:0]   eff_share,
    output logic              attr_reserved
);
    localparam int STORE_W = SH_W + ATTR_W;

    guard_ctx_t ctx;
    attr_reg_t  wr_val;
    attr_reg_t  cur;
    logic       allow;
    logic [STORE_W-1:0] store_q;
    logic       unused_wdata_hi;

    assign ctx = '{halted:        halted,
                   el3_present:   el3_present,
                   el2_enabled:   el2_enabled,
                   secure:        secure,
                   sec_debug_off: sec_debug_off,
                   halt_prio_opt: halt_prio_opt,
                   fgt_enable:    fgt_enable,
                   fgt_rd_trap:   fgt_rd_trap,
                   fgt_wr_trap:   fgt_wr_trap,
                   l2_owner:      l2_owner,
                   l3_owner:      l3_owner};

    assign wr_val          = attr_reg_t'(req_wdata[STORE_W-1:0]);
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:STORE_W];

    tbuf_access_decider u_decide (
        .valid      (req_valid),
        .write      (req_write),
        .level      (priv_lvl_e'(req_level)),
        .ctx        (ctx),
        .res_onehot (res_onehot),
        .res_class  (res_class),
        .allow      (allow)
    );

    tbuf_attr_store #(
        .DROP_WHILE_ENABLED(DROP_WHILE_ENABLED)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (allow && req_write),
        .buf_enable (buf_enable),
        .wr_val     (wr_val),
        .cur        (cur),
        .eff_share  (eff_share),
        .reserved   (attr_reserved)
    );

    assign store_q = cur;
    assign rd_data = (allow && !req_write) ? {{(DATA_W-STORE_W){1'b0}}, store_q} : '0;

endmodule

// File: rtl/tbuf_attr_guard_chk.sv
module tbuf_attr_guard_chk #(
    parameter int STORE_W = 10,
    parameter bit DROP    = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_level,
    input logic [STORE_W-1:0] wdata_lo,
    input logic               buf_enable,
    input logic [3:0]         res_onehot,
    input logic [5:0]         res_class,
    input logic [STORE_W-1:0] store_q,
    input logic [7:0]         attr_q,
    input logic [1:0]         eff_share
);
    // R8
    assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones(res_onehot) == 1);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> res_onehot == 4'b0000);
    assert_trap_class_R8: assert property (@(posedge clk) disable iff (rst)
        (res_onehot[1] || res_onehot[0]) |-> res_class == 6'h18);
    // R1
    assert_lvl0_undef_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd0) |-> res_onehot == 4'b0100);
    // R2
    assert_lvl3_allow_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd3) |-> res_onehot == 4'b1000);
    // R7
    assert_lvl2_no_l2trap_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd2) |-> !res_onehot[1]);
    // R9
    assert_write_stored_R9: assert property (@(posedge clk) disable iff (rst)
        (req_write && res_onehot[3] && !buf_enable) |=> store_q == $past(wdata_lo));
    // R10
    assert_drop_enabled_R10: assert property (@(posedge clk) disable iff (rst)
        (DROP && req_write && res_onehot[3] && buf_enable) |=> $stable(store_q));
    assert_blocked_write_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_write && res_onehot[3]) |=> $stable(store_q));
    // R11
    assert_device_outer_R11: assert property (@(posedge clk) disable iff (rst)
        (attr_q[7:4] == 4'b0000 || attr_q == 8'h44) |-> eff_share == 2'b10);
endmodule

bind tbuf_attr_guard tbuf_attr_guard_chk #(
    .STORE_W (10),
    .DROP    (DROP_WHILE_ENABLED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_level  (req_level),
    .wdata_lo   (req_wdata[9:0]),
    .buf_enable (buf_enable),
    .res_onehot (res_onehot),
    .res_class  (res_class),
    .store_q    (store_q),
    .attr_q     (store_q[7:0]),
    .eff_share  (eff_share)
);

// File: tb/tbuf_attr_guard_bench.sv
module tbuf_attr_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid, req_write;
    logic [1:0]  req_level;
    logic [63:0] req_wdata;
    logic        halted, el3_present, el2_enabled, secure, sec_debug_off;
    logic        halt_prio_opt, fgt_enable, fgt_rd_trap, fgt_wr_trap;
    logic [1:0]  l2_owner, l3_owner;
    logic        buf_enable;
    logic [3:0]  res_onehot;
    logic [5:0]  res_class;
    logic [63:0] rd_data;
    logic [1:0]  eff_share;
    logic        attr_reserved;

    tbuf_attr_guard u_tbuf_attr_guard (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [9:0] shadow;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model: 0 allow, 1 undef, 2 trap l2, 3 trap l3
    function automatic int model_outcome(output string tag);
        bit mism;
        if (req_level == 0) begin tag = "R1"; return 1; end
        if (req_level == 3) begin tag = "R2"; return 0; end
        mism = el3_present && (secure ? (l3_owner != 2'b01) : (l3_owner != 2'b11));
        if (halted && el3_present && sec_debug_off && halt_prio_opt && mism) begin
            tag = "R3"; return 1;
        end
        if (req_level == 1) begin
            if (el2_enabled && (!el3_present || fgt_enable) &&
                ((req_write && fgt_wr_trap) || (!req_write && fgt_rd_trap))) begin
                tag = "R4"; return 2;
            end
            if (el2_enabled && l2_owner[0] == 1'b0) begin tag = "R5"; return 2; end
        end
        if (mism) begin
            tag = "R6";
            if (halted && sec_debug_off) return 1;
            return 3;
        end
        tag = (req_level == 2) ? "R7" : "R6";
        return 0;
    endfunction

    function automatic logic [1:0] model_share(input logic [9:0] v);
        if (v[7:4] == 4'd0 || v[7:0] == 8'h44) return 2'b10;
        return v[9:8];
    endfunction

    function automatic logic model_rsvd(input logic [9:0] v);
        if (v[7:4] == 4'd0) return (v[3:0] != 4'h0 && v[3:0] != 4'h4 &&
                                    v[3:0] != 4'h8 && v[3:0] != 4'hC);
        if (v[7:0] == 8'h44) return 1'b0;
        return v[9:8] == 2'b01;
    endfunction

    task automatic step();
        string tag;
        int o;
        logic [3:0] e_res;
        logic [5:0] e_cls;
        logic [63:0] e_rd;
        bit wr_pending;
        logic [9:0] nxt;
        @(negedge clk);
        #1;
        o = model_outcome(tag);
        e_res = req_valid ? (4'b1000 >> o) : 4'b0000;
        e_cls = (req_valid && o >= 2) ? 6'h18 : 6'h00;
        e_rd  = (req_valid && !req_write && o == 0) ? {54'd0, shadow} : 64'd0;
        check(res_onehot == e_res, req_valid ? tag : "R8", {60'd0, res_onehot}, {60'd0, e_res});
        check(res_class == e_cls, "R8", {58'd0, res_class}, {58'd0, e_cls});
        check(rd_data == e_rd, "R9", rd_data, e_rd);
        check(eff_share == model_share(shadow), "R11", {62'd0, eff_share}, {62'd0, model_share(shadow)});
        check(attr_reserved == model_rsvd(shadow), "R12", {63'd0, attr_reserved}, {63'd0, model_rsvd(shadow)});
        wr_pending = req_valid && req_write && o == 0 && !buf_enable;
        nxt = req_wdata[9:0];
        @(posedge clk);
        #1;
        if (wr_pending) shadow = nxt;
    endtask

    task automatic open_ctx();
        req_valid = 1; req_write = 0; req_level = 2'd1; req_wdata = '0;
        halted = 0; el3_present = 1; el2_enabled = 1; secure = 0;
        sec_debug_off = 0; halt_prio_opt = 0; fgt_enable = 1;
        fgt_rd_trap = 0; fgt_wr_trap = 0; l2_owner = 2'b01; l3_owner = 2'b11;
        buf_enable = 0;
    endtask

    task automatic wr(input logic [1:0] lvl, input logic [63:0] d);
        req_write = 1; req_level = lvl; req_wdata = d; step();
        req_write = 0; step();   // read back one cycle later
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        shadow = '0;
        open_ctx();
        req_valid = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9 reset value, read from level 3
        req_valid = 1; req_level = 2'd3; step();
        req_valid = 0; step();                                      // R8 idle
        open_ctx(); req_level = 2'd0; step();                       // R1
        req_write = 1; step();                                      // R1 write
        // R2: hostile context at level 3
        l3_owner = 2'b00; l2_owner = 2'b00; fgt_rd_trap = 1; halted = 1;
        sec_debug_off = 1; halt_prio_opt = 1; req_level = 2'd3; req_write = 0; step();
        // R3 at level 1 and 2
        req_level = 2'd1; step();
        req_level = 2'd2; step();
        // R6 halted without option -> undef at last step; at level 2
        open_ctx(); req_level = 2'd2; l3_owner = 2'b00; halted = 1; sec_debug_off = 1; step();
        halted = 0; step();                                         // R6 trap l3
        secure = 1; l3_owner = 2'b01; step();                       // R6 secure match allowed
        // R4 direction-specific bits
        open_ctx(); fgt_rd_trap = 1; step();                        // read traps
        req_write = 1; req_wdata = 64'h0FF; step();                 // write ignores rd bit
        fgt_rd_trap = 0; fgt_wr_trap = 1; step();                   // write traps
        req_write = 0; step();                                      // read ignores wr bit
        fgt_enable = 0; req_write = 1; step();                      // gated off by level 3
        el3_present = 0; step();                                    // no level 3 -> applies
        // R5
        open_ctx(); l2_owner = 2'b10; step();
        el2_enabled = 0; step();
        // R7: level 2 ignores fgt and l2 owner
        open_ctx(); req_level = 2'd2; l2_owner = 2'b00; fgt_rd_trap = 1; step();
        // R9 / R11 / R12 stored values
        open_ctx();
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FF3F);  // share 11, attr 0x3F
        wr(2'd1, 64'h0000_0000_0000_0244); // share 10, attr 0x44 forced
        wr(2'd3, 64'h0000_0000_0000_03CC); // inner 11
        wr(2'd3, 64'h0000_0000_0000_01CC); // reserved share R12
        wr(2'd3, 64'h0000_0000_0000_0144); // override hides reserved share
        wr(2'd3, 64'h0000_0000_0000_0304); // device, legal subtype
        wr(2'd3, 64'h0000_0000_0000_0006); // device reserved subtype R12
        // R10: dropped while buffer enabled, and blocked write
        wr(2'd3, 64'h0000_0000_0000_00EE);
        buf_enable = 1; wr(2'd3, 64'h0000_0000_0000_0111);
        buf_enable = 0; wr(2'd0, 64'h0000_0000_0000_0222);
        // random run
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            req_valid = r[0] | r[1];
            req_write = r[2];
            req_level = r[4:3];
            req_wdata = {$urandom, $urandom};
            halted = r[5]; el3_present = r[6] | r[7]; el2_enabled = r[8];
            secure = r[9]; sec_debug_off = r[10]; halt_prio_opt = r[11];
            fgt_enable = r[12]; fgt_rd_trap = r[13] & r[14]; fgt_wr_trap = r[15] & r[16];
            l2_owner = r[18:17] | {1'b0, r[19]}; l3_owner = r[21:20] | {r[22], r[22]};
            buf_enable = r[23] & r[24];
            step();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule